// File: doc/BRIEF.md
# Secure Timer Compare Register Access Gate

This block judges a single system-register access request aimed at the secure physical timer's compare value. Each request carries the five instruction encoding fields, the direction (read or write), the current exception level and the platform and security configuration that bear on the decision. One cycle after a request strobe, the block reports exactly one verdict: the access may proceed, the access is an undefined instruction, or the access traps to exception level 3 with a 6-bit syndrome class code. When the encoding fields do not name this register, the block instead reports that the register was not selected and gives no verdict.

The block moves no register data and raises no exception itself. The decode and exception logic around it consumes the verdict. Requests arrive as a plain strobe with no ready signal. The block accepts a request on every cycle and so never applies back-pressure. Each response is valid for exactly the one cycle after its request, and the consumer must take it in that cycle, because nothing holds it longer. Read and write accesses follow the same permission rules.

Top module: `sec_tmr_cmp_perm`

## Requirements
- R1: The register is selected only when op0=2'b11, op1=3'b111, CRn=4'b1110, CRm=4'b0010 and op2=3'b010. For any other encoding, a valid request yields `rsp_unsel`=1 with `rsp_allow`, `rsp_undef` and `rsp_trap` all 0.
- R2: When the highest exception level (`top_el_present`=0) or 64-bit execution (`aa64_present`=0) is absent, every selected access is undefined.
- R3: Selected accesses with `cur_el`=0 or `cur_el`=2 are undefined. `cur_el` carries the level as an unsigned number.
- R4: Selected accesses with `cur_el`=3 are allowed when both features are present, whatever the security configuration.
- R5: At `cur_el`=1 with `cfg_ns`=1, the access is undefined.
- R6: At `cur_el`=1 with `cfg_ns`=0, when `dbg_undef_pri`=1 and `cfg_stmr_en`=0, the access is undefined. This check comes before the secure-EL2 check and before the trap.
- R7: At `cur_el`=1 with `cfg_ns`=0, when R6 does not apply and `cfg_sel2_en`=1, the access is undefined.
- R8: At `cur_el`=1 with `cfg_ns`=0 and `cfg_sel2_en`=0, when R6 does not apply and `cfg_stmr_en`=0, the access traps. When `dbg_undef`=1, it is undefined instead.
- R9: At `cur_el`=1 with `cfg_ns`=0, `cfg_sel2_en`=0 and `cfg_stmr_en`=1, the access is allowed regardless of the debug-disable inputs.
- R10: A read (`req_is_wr`=0) and a write (`req_is_wr`=1) with identical other inputs give identical responses.
- R11: While `rsp_vld`=1, exactly one of `rsp_allow`, `rsp_undef`, `rsp_trap` and `rsp_unsel` is 1. While `rsp_vld`=0, all four are 0.
- R12: `rsp_trap_class` equals 6'h18 when `rsp_trap`=1 and is 0 otherwise.
- R13: `rsp_vld` is 1 in exactly the cycle after each cycle with `req_vld`=1, so back-to-back requests give back-to-back responses. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe, one request per cycle |
| req_is_wr | input | 1 | 1 for a write, 0 for a read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| cur_el | input | 2 | Current exception level, 0 to 3 |
| top_el_present | input | 1 | Exception level 3 is implemented |
| aa64_present | input | 1 | 64-bit execution is implemented |
| cfg_ns | input | 1 | Non-secure configuration bit |
| cfg_stmr_en | input | 1 | Secure timer access enable from level 1 |
| cfg_sel2_en | input | 1 | Secure EL2 enable |
| dbg_undef_pri | input | 1 | Secure debug-disable undefined has priority |
| dbg_undef | input | 1 | Secure debug-disable forces undefined in place of the trap |
| rsp_vld | output | 1 | Response valid, one cycle after the request |
| rsp_allow | output | 1 | Access permitted |
| rsp_undef | output | 1 | Access is undefined |
| rsp_trap | output | 1 | Access traps to level 3 |
| rsp_trap_class | output | 6 | Syndrome class of the trap, 0 when not trapping |
| rsp_unsel | output | 1 | Encoding does not select this register |

## Verification
The bench targets the ordering inside the level-1 secure branch. The debug-priority case with the timer bit clear must yield undefined rather than trap, and a design that tested the trap first would report a trap there. Secure EL2 enabled with the timer bit clear must also yield undefined, and a design that tested the timer bit first would trap. Level 3 with every hostile configuration bit set must still be allowed, and a design that applied the level-1 checks too widely would refuse it. Every encoding field is disturbed one at a time, along with back-to-back strobes and paired read/write requests, so a matcher that ignores a field, a response that lingers or drops a cycle, or a direction-dependent verdict shows up as a wrong flag at the ports.

// File: rtl/stcp_pkg.sv
package stcp_pkg;

  typedef enum logic [1:0] {
    V_ALLOW = 2'd0,
    V_UNDEF = 2'd1,
    V_TRAP  = 2'd2
  } verdict_e;

  typedef struct packed {
    logic ns;
    logic stmr_en;
    logic sel2_en;
  } sec_cfg_t;

  typedef struct packed {
    logic pri;
    logic undef;
  } dbg_cfg_t;

endpackage

// File: rtl/stcp_enc_match.sv
module stcp_enc_match #(
  parameter int OP0_W = 2,
  parameter int OP1_W = 3,
  parameter int CRN_W = 4,
  parameter int CRM_W = 4,
  parameter int OP2_W = 3,
  parameter logic [OP0_W-1:0] ENC_OP0 = 2'b11,
  parameter logic [OP1_W-1:0] ENC_OP1 = 3'b111,
  parameter logic [CRN_W-1:0] ENC_CRN = 4'b1110,
  parameter logic [CRM_W-1:0] ENC_CRM = 4'b0010,
  parameter logic [OP2_W-1:0] ENC_OP2 = 3'b010
) (
  input  logic [OP0_W-1:0] op0,
  input  logic [OP1_W-1:0] op1,
  input  logic [CRN_W-1:0] crn,
  input  logic [CRM_W-1:0] crm,
  input  logic [OP2_W-1:0] op2,
  output logic             hit
);
  localparam int KEY_W = OP0_W + OP1_W + CRN_W + CRM_W + OP2_W;

  logic [KEY_W-1:0] key_in;
  logic [KEY_W-1:0] key_ref;

  assign key_in  = {op0, op1, crn, crm, op2};
  assign key_ref = {ENC_OP0, ENC_OP1, ENC_CRN, ENC_CRM, ENC_OP2};

  // Each field must match exactly; a reduction over the per-bit equality.
  assign hit = &(~(key_in ^ key_ref));
endmodule

// File: rtl/stcp_perm_tree.sv
module stcp_perm_tree
  import stcp_pkg::*;
#(
  parameter int EL_W = 2
) (
  input  logic [EL_W-1:0] el,
  input  logic            top_el_present,
  input  logic            aa64_present,
  input  sec_cfg_t        sec,
  input  dbg_cfg_t        dbg,
  output verdict_e        verdict
);
  localparam logic [EL_W-1:0] EL_USR = EL_W'(0);
  localparam logic [EL_W-1:0] EL_OS  = EL_W'(1);
  localparam logic [EL_W-1:0] EL_HYP = EL_W'(2);

  // Ordered decision: the first matching rule wins.
  always_comb begin
    verdict = V_ALLOW;
    if (!(top_el_present && aa64_present)) begin
      verdict = V_UNDEF;
    end else if (el == EL_USR || el == EL_HYP) begin
      verdict = V_UNDEF;
    end else if (el == EL_OS) begin
      if (sec.ns) begin
        verdict = V_UNDEF;
      end else if (dbg.pri && !sec.stmr_en) begin
        verdict = V_UNDEF;
      end else if (sec.sel2_en) begin
        verdict = V_UNDEF;
      end else if (!sec.stmr_en) begin
        verdict = dbg.undef ? V_UNDEF : V_TRAP;
      end else begin
        verdict = V_ALLOW;
      end
    end else begin
      verdict = V_ALLOW;
    end
  end
endmodule

// File: rtl/stcp_perm_select.sv
module stcp_perm_select
  import stcp_pkg::*;
#(
  parameter int EL_W   = 2,
  parameter int N_DIRS = 2
) (
  input  logic [EL_W-1:0] el,
  input  logic            is_wr,
  input  logic            top_el_present,
  input  logic            aa64_present,
  input  sec_cfg_t        sec,
  input  dbg_cfg_t        dbg,
  output verdict_e        verdict
);
  verdict_e v_dir [N_DIRS];

  // One tree per access direction; both carry the same rules today.
  for (genvar d = 0; d < N_DIRS; d++) begin : g_dir
    stcp_perm_tree #(.EL_W(EL_W)) u_tree (
      .el             (el),
      .top_el_present (top_el_present),
      .aa64_present   (aa64_present),
      .sec            (sec),
      .dbg            (dbg),
      .verdict        (v_dir[d])
    );
  end

  assign verdict = is_wr ? v_dir[1] : v_dir[0];
endmodule

// File: rtl/stcp_rsp_reg.sv
module stcp_rsp_reg
  import stcp_pkg::*;
#(
  parameter int               EC_W    = 6,
  parameter logic [EC_W-1:0]  TRAP_EC = 6'h18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_vld,
  input  logic            hit,
  input  verdict_e        verdict,
  output logic            rsp_vld,
  output logic            rsp_allow,
  output logic            rsp_undef,
  output logic            rsp_trap,
  output logic [EC_W-1:0] rsp_trap_class,
  output logic            rsp_unsel
);
  logic nxt_allow, nxt_undef, nxt_trap, nxt_unsel;

  always_comb begin
    nxt_allow = req_vld && hit && (verdict == V_ALLOW);
    nxt_undef = req_vld && hit && (verdict == V_UNDEF);
    nxt_trap  = req_vld && hit && (verdict == V_TRAP);
    nxt_unsel = req_vld && !hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld        <= 1'b0;
      rsp_allow      <= 1'b0;
      rsp_undef      <= 1'b0;
      rsp_trap       <= 1'b0;
      rsp_unsel      <= 1'b0;
      rsp_trap_class <= '0;
    end else begin
      rsp_vld        <= req_vld;
      rsp_allow      <= nxt_allow;
      rsp_undef      <= nxt_undef;
      rsp_trap       <= nxt_trap;
      rsp_unsel      <= nxt_unsel;
      rsp_trap_class <= nxt_trap ? TRAP_EC : '0;
    end
  end
endmodule

// File: rtl/sec_tmr_cmp_perm.sv
module sec_tmr_cmp_perm
  import stcp_pkg::*;
#(
  parameter int               EL_W    = 2,
  parameter int               EC_W    = 6,
  parameter logic [EC_W-1:0]  TRAP_EC = 6'h18,
  parameter int               OP0_W   = 2,
  parameter int               OP1_W   = 3,
  parameter int               CRN_W   = 4,
  parameter int               CRM_W   = 4,
  parameter int               OP2_W   = 3,
  parameter logic [OP0_W-1:0] ENC_OP0 = 2'b11,
  parameter logic [OP1_W-1:0] ENC_OP1 = 3'b111,
  parameter logic [CRN_W-1:0] ENC_CRN = 4'b1110,
  parameter logic [CRM_W-1:0] ENC_CRM = 4'b0010,
  parameter logic [OP2_W-1:0] ENC_OP2 = 3'b010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic             req_is_wr,
  input  logic [OP0_W-1:0] req_op0,
  input  logic [OP1_W-1:0] req_op1,
  input  logic [CRN_W-1:0] req_crn,
  input  logic [CRM_W-1:0] req_crm,
  input  logic [OP2_W-1:0] req_op2,
  input  logic [EL_W-1:0]  cur_el,
  input  logic             top_el_present,
  input  logic             aa64_present,
  input  logic             cfg_ns,
  input  logic             cfg_stmr_en,
  input  logic             cfg_sel2_en,
  input  logic             dbg_undef_pri,
  input  logic             dbg_undef,
  output logic             rsp_vld,
  output logic             rsp_allow,
  output logic             rsp_undef,
  output logic             rsp_trap,
  output logic [EC_W-1:0]  rsp_trap_class,
  output logic             rsp_unsel
);
  logic     sel_hit;
  verdict_e verdict;
  sec_cfg_t sec;
  dbg_cfg_t dbg;

  assign sec = '{ns: cfg_ns, stmr_en: cfg_stmr_en, sel2_en: cfg_sel2_en};
  assign dbg = '{pri: dbg_undef_pri, undef: dbg_undef};

  stcp_enc_match #(
    .OP0_W(OP0_W), .OP1_W(OP1_W), .CRN_W(CRN_W), .CRM_W(CRM_W), .OP2_W(OP2_W),
    .ENC_OP0(ENC_OP0), .ENC_OP1(ENC_OP1), .ENC_CRN(ENC_CRN),
    .ENC_CRM(ENC_CRM), .ENC_OP2(ENC_OP2)
  ) u_match (
    .op0 (req_op0),
    .op1 (req_op1),
    .crn (req_crn),
    .crm (req_crm),
    .op2 (req_op2),
    .hit (sel_hit)
  );

  stcp_perm_select #(.EL_W(EL_W), .N_DIRS(2)) u_sel (
    .el             (cur_el),
    .is_wr          (req_is_wr),
    .top_el_present (top_el_present),
    .aa64_present   (aa64_present),
    .sec            (sec),
    .dbg            (dbg),
    .verdict        (verdict)
  );

  stcp_rsp_reg #(.EC_W(EC_W), .TRAP_EC(TRAP_EC)) u_rsp (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_vld        (req_vld),
    .hit            (sel_hit),
    .verdict        (verdict),
    .rsp_vld        (rsp_vld),
    .rsp_allow      (rsp_allow),
    .rsp_undef      (rsp_undef),
    .rsp_trap       (rsp_trap),
    .rsp_trap_class (rsp_trap_class),
    .rsp_unsel      (rsp_unsel)
  );
endmodule

// File: rtl/sec_tmr_cmp_perm_chk.sv
module sec_tmr_cmp_perm_chk #(
  parameter int              EL_W    = 2,
  parameter int              EC_W    = 6,
  parameter logic [EC_W-1:0] TRAP_EC = 6'h18
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_vld,
  input logic            sel_hit,
  input logic [EL_W-1:0] cur_el,
  input logic            top_el_present,
  input logic            aa64_present,
  input logic            rsp_vld,
  input logic            rsp_allow,
  input logic            rsp_undef,
  input logic            rsp_trap,
  input logic [EC_W-1:0] rsp_trap_class,
  input logic            rsp_unsel
);
  // R13
  lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);
  // R13
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);
  // R11
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> $countones({rsp_allow, rsp_undef, rsp_trap, rsp_unsel}) == 1);
  // R11
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |-> {rsp_allow, rsp_undef, rsp_trap, rsp_unsel} == 4'b0);
  // R12
  class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> rsp_trap_class == TRAP_EC);
  // R12
  class_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_trap |-> rsp_trap_class == '0);
  // R1
  unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !sel_hit) |=> rsp_unsel);
  // R2
  absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && sel_hit && !(top_el_present && aa64_present)) |=> rsp_undef);
  // R3
  el_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && sel_hit && !cur_el[0]) |=> rsp_undef);
  // R4
  el_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && sel_hit && cur_el == EL_W'(3) && top_el_present && aa64_present)
      |=> rsp_allow);
endmodule

bind sec_tmr_cmp_perm sec_tmr_cmp_perm_chk #(
  .EL_W(EL_W), .EC_W(EC_W), .TRAP_EC(TRAP_EC)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_vld        (req_vld),
  .sel_hit        (sel_hit),
  .cur_el         (cur_el),
  .top_el_present (top_el_present),
  .aa64_present   (aa64_present),
  .rsp_vld        (rsp_vld),
  .rsp_allow      (rsp_allow),
  .rsp_undef      (rsp_undef),
  .rsp_trap       (rsp_trap),
  .rsp_trap_class (rsp_trap_class),
  .rsp_unsel      (rsp_unsel)
);

// File: tb/sec_tmr_cmp_perm_bench.sv
module sec_tmr_cmp_perm_bench;
  // Vector: [17:16] el, 15 top, 14 aa64, 13 ns, 12 stmr, 11 sel2, 10 pri,
  //         9 dbg, 8 wr, [7:4] requirement number, [1:0] expected
  //         (0 allow, 1 undef, 2 trap)
  localparam int NV = 21;
  localparam logic [17:0] VEC [NV] = '{
    {2'd3, 8'b0_1_0_1_0_0_0_0, 4'd2, 2'b00, 2'd1},  // R2
    {2'd3, 8'b1_0_0_1_0_0_0_1, 4'd2, 2'b00, 2'd1},  // R2
    {2'd1, 8'b0_0_0_1_0_0_0_0, 4'd2, 2'b00, 2'd1},  // R2
    {2'd0, 8'b1_1_0_1_0_0_0_0, 4'd3, 2'b00, 2'd1},  // R3
    {2'd2, 8'b1_1_0_1_0_0_0_1, 4'd3, 2'b00, 2'd1},  // R3
    {2'd0, 8'b1_1_1_0_1_1_1_0, 4'd3, 2'b00, 2'd1},  // R3
    {2'd3, 8'b1_1_0_0_1_1_1_0, 4'd4, 2'b00, 2'd0},  // R4
    {2'd3, 8'b1_1_1_1_0_0_0_1, 4'd4, 2'b00, 2'd0},  // R4
    {2'd1, 8'b1_1_1_1_0_0_0_0, 4'd5, 2'b00, 2'd1},  // R5
    {2'd1, 8'b1_1_1_0_0_0_0_1, 4'd5, 2'b00, 2'd1},  // R5
    {2'd1, 8'b1_1_0_0_0_1_0_0, 4'd6, 2'b00, 2'd1},  // R6
    {2'd1, 8'b1_1_0_0_1_1_0_1, 4'd6, 2'b00, 2'd1},  // R6
    {2'd1, 8'b1_1_0_1_1_0_0_0, 4'd7, 2'b00, 2'd1},  // R7
    {2'd1, 8'b1_1_0_1_1_1_1_1, 4'd7, 2'b00, 2'd1},  // R7
    {2'd1, 8'b1_1_0_0_1_0_0_0, 4'd7, 2'b00, 2'd1},  // R7
    {2'd1, 8'b1_1_0_0_0_0_0_0, 4'd8, 2'b00, 2'd2},  // R8
    {2'd1, 8'b1_1_0_0_0_0_0_1, 4'd8, 2'b00, 2'd2},  // R8
    {2'd1, 8'b1_1_0_0_0_0_1_0, 4'd8, 2'b00, 2'd1},  // R8
    {2'd1, 8'b1_1_0_1_0_0_0_0, 4'd9, 2'b00, 2'd0},  // R9
    {2'd1, 8'b1_1_0_1_0_1_1_1, 4'd9, 2'b00, 2'd0},  // R9
    {2'd1, 8'b1_1_0_1_0_0_1_0, 4'd9, 2'b00, 2'd0}   // R9
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_vld = 1'b0, req_is_wr = 1'b0;
  logic [1:0] req_op0 = 2'b11;
  logic [2:0] req_op1 = 3'b111;
  logic [3:0] req_crn = 4'b1110;
  logic [3:0] req_crm = 4'b0010;
  logic [2:0] req_op2 = 3'b010;
  logic [1:0] cur_el = 2'd0;
  logic top_el_present = 1'b1, aa64_present = 1'b1;
  logic cfg_ns = 1'b0, cfg_stmr_en = 1'b0, cfg_sel2_en = 1'b0;
  logic dbg_undef_pri = 1'b0, dbg_undef = 1'b0;
  logic rsp_vld, rsp_allow, rsp_undef, rsp_trap, rsp_unsel;
  logic [5:0] rsp_trap_class;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sec_tmr_cmp_perm u_sec_tmr_cmp_perm (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_is_wr(req_is_wr),
    .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn),
    .req_crm(req_crm), .req_op2(req_op2), .cur_el(cur_el),
    .top_el_present(top_el_present), .aa64_present(aa64_present),
    .cfg_ns(cfg_ns), .cfg_stmr_en(cfg_stmr_en), .cfg_sel2_en(cfg_sel2_en),
    .dbg_undef_pri(dbg_undef_pri), .dbg_undef(dbg_undef),
    .rsp_vld(rsp_vld), .rsp_allow(rsp_allow), .rsp_undef(rsp_undef),
    .rsp_trap(rsp_trap), .rsp_trap_class(rsp_trap_class),
    .rsp_unsel(rsp_unsel)
  );

  // Observed bundle: {vld, allow, undef, trap, unsel, class}
  function automatic logic [10:0] obs();
    return {rsp_vld, rsp_allow, rsp_undef, rsp_trap, rsp_unsel, rsp_trap_class};
  endfunction

  function automatic logic [10:0] expect_code(input logic [1:0] code);
    case (code)
      2'd0:    return {5'b11000, 6'h00};
      2'd1:    return {5'b10100, 6'h00};
      2'd2:    return {5'b10010, 6'h18};
      default: return {5'b10001, 6'h00};  // code 3: not selected
    endcase
  endfunction

  task automatic check(input string tag, input logic [10:0] got, input logic [10:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic load(input logic [17:0] v);
    cur_el = v[17:16]; top_el_present = v[15]; aa64_present = v[14];
    cfg_ns = v[13]; cfg_stmr_en = v[12]; cfg_sel2_en = v[11];
    dbg_undef_pri = v[10]; dbg_undef = v[9]; req_is_wr = v[8];
  endtask

  task automatic set_enc(input logic [15:0] e);
    {req_op0, req_op1, req_crn, req_crm, req_op2} = e;
  endtask

  localparam logic [15:0] ENC_OK = {2'b11, 3'b111, 4'b1110, 4'b0010, 3'b010};

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    check("R13 reset", obs(), 11'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 idle", obs(), 11'd0);

    // Table walk: each vector is one request, result one cycle later.
    for (int i = 0; i < NV; i++) begin
      load(VEC[i]);
      req_vld = 1'b1;
      @(negedge clk);
      req_vld = 1'b0;
      check($sformatf("R%0d vec%0d (R12 class)", VEC[i][7:4], i),
            obs(), expect_code(VEC[i][1:0]));
    end

    // R1: disturb each encoding field in turn with an allowed config.
    load({2'd3, 8'b1_1_0_1_0_0_0_0, 8'd0});
    for (int f = 0; f < 5; f++) begin
      logic [15:0] e;
      e = ENC_OK;
      case (f)
        0: e[15:14] = 2'b10;
        1: e[13:11] = 3'b011;
        2: e[10:7]  = 4'b1111;
        3: e[6:3]   = 4'b0011;
        default: e[2:0] = 3'b001;
      endcase
      set_enc(e);
      req_vld = 1'b1;
      @(negedge clk);
      req_vld = 1'b0;
      check($sformatf("R1 field%0d", f), obs(), expect_code(2'd3));
    end
    set_enc(ENC_OK);

    // R10: same trap config read then write, back to back.
    load({2'd1, 8'b1_1_0_0_0_0_0_0, 8'd0});
    req_vld = 1'b1;
    @(negedge clk);
    check("R10 read", obs(), expect_code(2'd2));
    req_is_wr = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
    check("R10 write", obs(), expect_code(2'd2));

    // R13: back-to-back with a differing verdict, then a quiet cycle.
    load({2'd1, 8'b1_1_0_1_0_0_0_0, 8'd0});
    req_vld = 1'b1;
    @(negedge clk);
    check("R13 b2b first", obs(), expect_code(2'd0));
    cur_el = 2'd2;
    @(negedge clk);
    req_vld = 1'b0;
    check("R13 b2b second", obs(), expect_code(2'd1));
    @(negedge clk);
    check("R13 drop after", obs(), 11'd0);

    // R13: reset while a response is held clears it.
    req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R13 reset clears", obs(), 11'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule